// File: doc/BRIEF.md
# Simplified AXI-Lite Register Slave

This block is a bank of four 32-bit memory-mapped registers meant to sit on one output of an AXI-Lite splitter or crossbar. It uses a reduced AXI-Lite subset with no back-pressure. The upstream side drives write-address valid and write-data valid from one strobe. It keeps both response-ready signals high. The slave therefore never stalls and needs no handshake state machine.

A write is accepted in any cycle where the write strobe is high. The register picked by the write address takes the data on that clock edge, and only the byte lanes whose strobe bit is set change. A read is accepted in any cycle where the read strobe is high. The read data register is loaded on that edge from the addressed register. Each response valid is the request valid delayed by one clock, and both response codes are always OKAY.

Top module: `lreg_slave`

## Requirements
- R1: The write-address ready, write-data ready and read-address ready outputs are 1 in every cycle, including during reset.
- R2: `b_valid` in a cycle equals `wr_valid` in the previous cycle, and is 0 in the first cycle after reset.
- R3: `r_valid` in a cycle equals `rd_valid` in the previous cycle, and is 0 in the first cycle after reset.
- R4: `b_resp` and `r_resp` are always 2'b00 (OKAY).
- R5: On a write, the register index is address bits [3:2], so register i sits at byte offset 4*i. Address bits [1:0] and bits above bit 3 are ignored.
- R6: Write strobe bit b gates data bits [8b+7:8b]. A lane whose strobe bit is 0 keeps its old value, and registers other than the selected one do not change.
- R7: A read loads `r_data` on the clock edge from the register selected by bits [3:2] of `rd_addr`, so the value is present while `r_valid` is high. Without a read, `r_data` holds its value.
- R8: If a read and a write hit the same register in the same cycle, the read returns the value from before the write.
- R9: A synchronous active-low reset clears all four registers, `r_data`, `b_valid` and `r_valid` to 0.
- R10: While `wr_valid` is 0, the write address, data and strobes have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | Shared write-address and write-data valid |
| wr_addr | input | ADDR_W (8) | Write byte address |
| wr_data | input | DATA_W (32) | Write data |
| wr_strb | input | DATA_W/8 (4) | Byte-lane write enables |
| aw_ready | output | 1 | Write-address ready, constant 1 |
| w_ready | output | 1 | Write-data ready, constant 1 |
| b_valid | output | 1 | Write response valid |
| b_resp | output | 2 | Write response code, always OKAY |
| rd_valid | input | 1 | Read-address valid |
| rd_addr | input | ADDR_W (8) | Read byte address |
| ar_ready | output | 1 | Read-address ready, constant 1 |
| r_valid | output | 1 | Read data valid |
| r_data | output | DATA_W (32) | Read data |
| r_resp | output | 2 | Read response code, always OKAY |

## Verification
Directed writes with all strobes set fill each register with a distinct value, and reads of every offset then show whether the index decode is correct. Single-lane and mixed strobe patterns separate correct byte gating from whole-word writes. Addresses with the low two bits or the upper bits set show whether those bits are ignored. Idle cycles that carry random address, data and strobes check that a write needs its valid. Reads and writes to the same register in the same cycle check that the read returns the old value. A long run with random valids, addresses and strobes, checked against a bench model, covers back-to-back and overlapping traffic and a reset in the middle of the run.

// File: rtl/lreg_pkg.sv
// Shared constants for the simplified register slave.
// Assumes: response encoding follows the standard AXI response codes.
package lreg_pkg;
    localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/lreg_bank.sv
// Register storage with per-byte write enables.
// Assumes: a write is taken in any cycle wr_valid is high (no stall possible);
// index comes from the address bits just above the byte offset.
module lreg_bank #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int NREGS  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_valid,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [DATA_W/8-1:0]      wr_strb,
    output logic [NREGS*DATA_W-1:0]  bank_q
);
    localparam int STRB_W = DATA_W / 8;
    localparam int LSB    = $clog2(STRB_W);
    localparam int IDX_W  = (NREGS > 1) ? $clog2(NREGS) : 1;

    logic [IDX_W-1:0] widx;
    logic             unused_wr_addr;

    // Decode the target register index from the write address.
    assign widx           = wr_addr[LSB +: IDX_W];
    assign unused_wr_addr = ^wr_addr;

    for (genvar r = 0; r < NREGS; r++) begin : g_reg
        for (genvar b = 0; b < STRB_W; b++) begin : g_lane
            logic hit;
            assign hit = wr_valid && (widx == IDX_W'(r)) && wr_strb[b];

            // Byte lane storage: loads only when its register and strobe are selected.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    bank_q[r*DATA_W + 8*b +: 8] <= '0;
                else if (hit)
                    bank_q[r*DATA_W + 8*b +: 8] <= wr_data[8*b +: 8];
            end

            assert_lane_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_valid && !((widx == IDX_W'(r)) && wr_strb[b]))
                |=> $stable(bank_q[r*DATA_W + 8*b +: 8]));

            assert_lane_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_valid && (widx == IDX_W'(r)) && wr_strb[b])
                |=> (bank_q[r*DATA_W + 8*b +: 8] == $past(wr_data[8*b +: 8])));
        end
    end

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> $stable(bank_q));
endmodule

// File: rtl/lreg_rdport.sv
// Registered read port: captures the addressed register when a read is strobed.
// Assumes: the bank input shows the pre-write contents in the read cycle, so a
// colliding write is not forwarded.
module lreg_rdport #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int NREGS  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_valid,
    input  logic [ADDR_W-1:0]        rd_addr,
    input  logic [NREGS*DATA_W-1:0]  bank_q,
    output logic [DATA_W-1:0]        r_data
);
    localparam int LSB   = $clog2(DATA_W / 8);
    localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1;

    logic [IDX_W-1:0]  ridx;
    logic [DATA_W-1:0] sel_word;
    logic              unused_rd_addr;

    // Pick the addressed word out of the flattened bank.
    assign ridx           = rd_addr[LSB +: IDX_W];
    assign sel_word       = bank_q[ridx*DATA_W +: DATA_W];
    assign unused_rd_addr = ^rd_addr;

    // Read data register: loads on a read strobe, otherwise holds.
    always_ff @(posedge clk) begin
        if (!rst_n)
            r_data <= '0;
        else if (rd_valid)
            r_data <= sel_word;
    end

    assert_read_old_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> (r_data == $past(bank_q[ridx*DATA_W +: DATA_W])));

    assert_rdata_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> $stable(r_data));
endmodule

// File: rtl/lreg_resp.sv
// Response strobe generator: each valid is its request valid one clock later.
// Assumes: the upstream ready inputs are always high, so a strobe never waits.
module lreg_resp (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_valid,
    input  logic rd_valid,
    output logic b_valid,
    output logic r_valid
);
    // One-cycle delay of both request strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_valid <= 1'b0;
            r_valid <= 1'b0;
        end else begin
            b_valid <= wr_valid;
            r_valid <= rd_valid;
        end
    end
endmodule

// File: rtl/lreg_slave.sv
// Top of the simplified AXI-Lite register slave: four byte-strobed registers,
// ready outputs tied high, fixed one-cycle response strobes, OKAY responses.
// Assumes: write-address and write-data valids are one shared strobe and both
// response readies are held high upstream.
module lreg_slave
    import lreg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int NREGS  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_valid,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [DATA_W/8-1:0]   wr_strb,
    output logic                  aw_ready,
    output logic                  w_ready,
    output logic                  b_valid,
    output logic [1:0]            b_resp,
    input  logic                  rd_valid,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic                  ar_ready,
    output logic                  r_valid,
    output logic [DATA_W-1:0]     r_data,
    output logic [1:0]            r_resp
);
    logic [NREGS*DATA_W-1:0] bank_q;

    // No back-pressure: every request is accepted the cycle it appears.
    assign aw_ready = 1'b1;
    assign w_ready  = 1'b1;
    assign ar_ready = 1'b1;

    // Responses never carry an error.
    assign b_resp = RESP_OKAY;
    assign r_resp = RESP_OKAY;

    lreg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREGS(NREGS)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_strb(wr_strb), .bank_q(bank_q));

    lreg_rdport #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREGS(NREGS)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_addr(rd_addr),
        .bank_q(bank_q), .r_data(r_data));

    lreg_resp u_resp (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .rd_valid(rd_valid),
        .b_valid(b_valid), .r_valid(r_valid));

    assert_bvalid_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> b_valid);
    assert_bvalid_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> !b_valid);
    assert_rvalid_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> r_valid);
    assert_rvalid_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> !r_valid);
endmodule

// File: tb/tb_lreg_slave.sv
module tb_lreg_slave;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int STRB_W = DATA_W / 8;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              wr_valid, rd_valid;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [DATA_W-1:0] wr_data;
    logic [STRB_W-1:0] wr_strb;
    logic              aw_ready, w_ready, ar_ready, b_valid, r_valid;
    logic [1:0]        b_resp, r_resp;
    logic [DATA_W-1:0] r_data;

    int vectors = 0;
    int miscompares = 0;

    logic [DATA_W-1:0] model [4];
    logic [DATA_W-1:0] exp_rdata;
    logic              exp_bvalid, exp_rvalid;

    always #5 clk = ~clk;

    lreg_slave dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_strb(wr_strb), .aw_ready(aw_ready),
        .w_ready(w_ready), .b_valid(b_valid), .b_resp(b_resp),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .ar_ready(ar_ready),
        .r_valid(r_valid), .r_data(r_data), .r_resp(r_resp));

    function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old_v,
            input logic [DATA_W-1:0] new_v, input logic [STRB_W-1:0] strb);
        logic [DATA_W-1:0] res = old_v;
        for (int b = 0; b < STRB_W; b++)
            if (strb[b]) res[8*b +: 8] = new_v[8*b +: 8];
        return res;
    endfunction

    function automatic int reg_index(input logic [ADDR_W-1:0] a);
        return int'(a[3:2]);
    endfunction

    task automatic check(input string req, input string what,
                         input logic [DATA_W-1:0] got, input logic [DATA_W-1:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s %s got %0h exp %0h", req, what, got, exp);
        end
    endtask

    task automatic check_all(input string req);
        check("R1", "aw_ready", 32'(aw_ready), 32'd1);
        check("R1", "w_ready", 32'(w_ready), 32'd1);
        check("R1", "ar_ready", 32'(ar_ready), 32'd1);
        check("R2", "b_valid", 32'(b_valid), 32'(exp_bvalid));
        check("R3", "r_valid", 32'(r_valid), 32'(exp_rvalid));
        check("R4", "b_resp", 32'(b_resp), 32'd0);
        check("R4", "r_resp", 32'(r_resp), 32'd0);
        check(req, "r_data", r_data, exp_rdata);
    endtask

    // One clock: drive, update model, wait past the edge, compare.
    task automatic step(input logic wv, input logic [ADDR_W-1:0] wa,
                        input logic [DATA_W-1:0] wd, input logic [STRB_W-1:0] ws,
                        input logic rv, input logic [ADDR_W-1:0] ra, input string req);
        wr_valid = wv; wr_addr = wa; wr_data = wd; wr_strb = ws;
        rd_valid = rv; rd_addr = ra;
        if (rv) exp_rdata = model[reg_index(ra)];
        if (wv) model[reg_index(wa)] = merge(model[reg_index(wa)], wd, ws);
        exp_bvalid = wv;
        exp_rvalid = rv;
        @(posedge clk);
        #2;
        check_all(req);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wr_valid = 1'b1; rd_valid = 1'b1;
        wr_addr = '0; rd_addr = '0; wr_data = '1; wr_strb = '1;
        @(posedge clk); @(posedge clk);
        #2;
        for (int i = 0; i < 4; i++) model[i] = '0;
        exp_rdata = '0; exp_bvalid = 1'b0; exp_rvalid = 1'b0;
        check_all("R9");
        rst_n = 1'b1;
        wr_valid = 1'b0; rd_valid = 1'b0;
    endtask

    initial begin
        #1_000_000;
        miscompares++;
        $display("FAIL watchdog expired got 0 exp 1");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5678));
        do_reset();
        // R9: all registers read back zero after reset
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1, 8'(4*i), "R9");
        // R5: full writes to each offset, then read each back
        for (int i = 0; i < 4; i++) step(1, 8'(4*i), 32'hA0B0C0D0 + 32'(i), 4'hF, 0, 0, "R5");
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1, 8'(4*i), "R7");
        // R5: low byte-offset bits and upper bits ignored
        step(1, 8'hF7, 32'h1122_3344, 4'hF, 0, 0, "R5");
        step(0, 0, 0, 0, 1, 8'h04, "R5");
        step(0, 0, 0, 0, 1, 8'h35, "R5");
        // R6: single lanes and mixed strobes
        step(1, 8'h00, 32'hFFFF_FFFF, 4'b0001, 0, 0, "R6");
        step(0, 0, 0, 0, 1, 8'h00, "R6");
        step(1, 8'h08, 32'h5566_7788, 4'b1010, 0, 0, "R6");
        step(0, 0, 0, 0, 1, 8'h08, "R6");
        step(1, 8'h0C, 32'hDEAD_BEEF, 4'b0000, 0, 0, "R6");
        step(0, 0, 0, 0, 1, 8'h0C, "R6");
        // R10: idle cycles with random write fields
        for (int i = 0; i < 6; i++) step(0, 8'($urandom), $urandom, 4'hF, 0, 0, "R10");
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1, 8'(4*i), "R10");
        // R8: collision returns old value, then new value
        step(1, 8'h04, 32'hCAFE_F00D, 4'hF, 1, 8'h04, "R8");
        step(0, 0, 0, 0, 1, 8'h04, "R8");
        // R7: r_data holds with no read
        step(1, 8'h00, 32'h0BAD_0BAD, 4'hF, 0, 0, "R7");
        step(0, 0, 0, 0, 0, 0, "R7");
        // Random traffic
        for (int i = 0; i < 3000; i++) begin
            step(1'($urandom), 8'($urandom), $urandom, 4'($urandom),
                 1'($urandom), 8'($urandom), "R7");
            if (i == 1500) begin
                do_reset();
                for (int k = 0; k < 4; k++) step(0, 0, 0, 0, 1, 8'(4*k), "R9");
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule